// File: doc/BRIEF.md
# Dual-Rail Spacer Gate Cell with 4-Bit XOR Datapath

This block provides gate cells for power-balanced logic in which every logical bit travels on a pair of wires. A data word is always separated from the next one by a spacer word. As a result, the same number of wires rise when data arrives and the same number fall when the spacer returns, whatever the data values are. The basic cell `dr_cell` takes two rail pairs and drives two rail pairs. Each output pair can be read in rail order or with its rails exchanged, and the four readings give NAND, AND, NOR and OR. A rail-exchange stage `dr_inv` provides NOT.

The top level chains the cells into a W-bit (default 4) dual-rail XOR, with the XNOR taken from a rail exchange. Both results are captured in registers on each clock edge. A phase monitor checks each captured word, using the states SPACER, FILL, DATA, DRAIN and FAULT:

- SPACER to DATA on an all-valid word, and SPACER to FILL on a partial word.
- FILL to DATA on an all-valid word, and FILL back to SPACER on an all-spacer word.
- DATA holds on an identical valid word, goes to DRAIN on a partial word, goes to SPACER on an all-spacer word, and goes to FAULT on a different valid word.
- DRAIN goes to FAULT on an all-valid word and to SPACER on an all-spacer word.
- FAULT leaves only on an all-spacer word, which takes it to SPACER.

Any other word keeps the current state. Reset enters SPACER.

Top module: `dr_xor_top`

## Requirements
- R1: Bit i of a word sits on pair [2i+1:2i]. The upper wire is the true rail: 10 means logic 1, 01 means logic 0, and 00 and 11 are spacers.
- R2: With both cell operands valid, output O read as given is NAND(A,B), and O with its rails exchanged is AND(A,B).
- R3: With both cell operands valid, output R read as given is NOR(A,B), and R with its rails exchanged is OR(A,B).
- R4: A cell input of 00,00 drives O=R=11, and an input of 11,11 drives O=R=00. At the top, an all-00 input word yields all-00 outputs and an all-11 input word yields all-11 outputs.
- R5: If either cell operand is a spacer, both outputs are spacers whose polarity is the inverse of A's spacer when A is a spacer, and otherwise the inverse of B's. A valid code never appears on the outputs in this case.
- R6: NOT is a rail exchange. Every valid pair of `xnor_dr` is the opposite value of the matching pair of `xor_dr`.
- R7: One edge after inputs are applied, each pair of `xor_dr` holds the XOR of the operand bits when both are valid. Otherwise it holds the spacer of A (or of B when A is valid).
- R8: During reset both output words are all zero (spacer) and `word_ok` and `seq_fault` are low.
- R9: `word_ok` is high exactly while the monitor is in DATA, that is, when the captured word is all valid and was reached through SPACER or FILL.
- R10: `seq_fault` rises when a valid word differing from the held one is captured straight after DATA, or when any valid word is captured from DRAIN. It clears only on an all-spacer word.
- R11: Between an all-00 spacer word and any all-valid word, in either direction, exactly 2W of the 4W output wires toggle.
- R12: Capturing the same valid word again keeps `word_ok` high and `seq_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low reset |
| a_dr | input | 2W | Operand A, dual-rail word |
| b_dr | input | 2W | Operand B, dual-rail word |
| xor_dr | output | 2W | Registered dual-rail A XOR B |
| xnor_dr | output | 2W | Registered dual-rail A XNOR B |
| word_ok | output | 1 | Captured word is complete, correctly sequenced data |
| seq_fault | output | 1 | Data followed data without an intervening spacer |

## Verification
The assertions assume the operand words are stable around each rising edge and are held at the all-00 spacer during reset, so that the first sample after reset compares against known inputs. The bench changes operands only on the falling edge, keeps them at zero while reset is low, and samples one nanosecond after the capturing edge. Rules that relate a captured word to the inputs of the previous edge are enabled only once a full cycle has passed since reset.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef logic [1:0] dr_pair_t;

    localparam dr_pair_t DR_ONE  = 2'b10;
    localparam dr_pair_t DR_ZERO = 2'b01;

    function automatic logic pair_valid(input dr_pair_t p);
        return p[1] ^ p[0];
    endfunction

    function automatic dr_pair_t pair_swap(input dr_pair_t p);
        return {p[0], p[1]};
    endfunction

    typedef enum logic [2:0] {
        S_SPACER = 3'd0,
        S_FILL   = 3'd1,
        S_DATA   = 3'd2,
        S_DRAIN  = 3'd3,
        S_FAULT  = 3'd4
    } phase_t;

endpackage

// File: rtl/dr_cell.sv
module dr_cell
    import dr_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [1:0] o,
    output logic [1:0] r
);

    logic va;
    logic vb;
    logic gov;

    assign va = pair_valid(a);
    assign vb = pair_valid(b);

    always_comb begin
        gov = a[1];
        o   = 2'b00;
        r   = 2'b00;
        unique case ({va, vb})
            2'b11: begin
                // true rail / false rail of each function
                o = {~(a[1] & b[1]), ~(a[0] | b[0])};
                r = {~(a[1] | b[1]), ~(a[0] & b[0])};
            end
            2'b10: begin
                gov = b[1];
                o   = {~gov, ~gov};
                r   = {~gov, ~gov};
            end
            2'b01, 2'b00: begin
                gov = a[1];
                o   = {~gov, ~gov};
                r   = {~gov, ~gov};
            end
            default: begin
                o = 2'b00;
                r = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/dr_inv.sv
module dr_inv #(
    parameter int W = 1
) (
    input  logic [2*W-1:0] x,
    output logic [2*W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_swap
        assign y[2*i+1] = x[2*i];
        assign y[2*i]   = x[2*i+1];
    end

endmodule

// File: rtl/dr_xor_slice.sv
module dr_xor_slice (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [1:0] x
);

    logic [1:0] nand_p, nor_p;
    logic [1:0] and_p, or_p, nand2_p, x_inv;
    logic [1:0] unused_r;

    dr_cell u_lvl1 (.a(a), .b(b), .o(nand_p), .r(nor_p));

    dr_inv #(.W(1)) u_and (.x(nand_p), .y(and_p));
    dr_inv #(.W(1)) u_or  (.x(nor_p),  .y(or_p));

    // NOT(and) via rail exchange of the AND pair gives NAND again
    dr_inv #(.W(1)) u_nand (.x(and_p), .y(nand2_p));

    // xor = or AND (not and): the AND reading of level two is O swapped
    dr_cell u_lvl2 (.a(or_p), .b(nand2_p), .o(x_inv), .r(unused_r));

    dr_inv #(.W(1)) u_out (.x(x_inv), .y(x));

endmodule

// File: rtl/dr_phase_mon.sv
module dr_phase_mon
    import dr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] nxt,
    input  logic [2*W-1:0] cur,
    output logic           word_ok,
    output logic           seq_fault
);

    localparam int NW = 2 * W;

    phase_t st, st_nx;
    logic nv, ns, same;

    function automatic logic all_valid(input logic [NW-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < W; i++) ok &= pair_valid(w[2*i +: 2]);
        return ok;
    endfunction

    function automatic logic all_spacer(input logic [NW-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < W; i++) ok &= ~pair_valid(w[2*i +: 2]);
        return ok;
    endfunction

    assign nv   = all_valid(nxt);
    assign ns   = all_spacer(nxt);
    assign same = (nxt == cur);

    always_comb begin
        st_nx = st;
        unique case (st)
            S_SPACER, S_FILL: begin
                if (nv)      st_nx = S_DATA;
                else if (ns) st_nx = S_SPACER;
                else         st_nx = S_FILL;
            end
            S_DATA: begin
                if (nv && same) st_nx = S_DATA;
                else if (nv)    st_nx = S_FAULT;
                else if (ns)    st_nx = S_SPACER;
                else            st_nx = S_DRAIN;
            end
            S_DRAIN: begin
                if (nv)      st_nx = S_FAULT;
                else if (ns) st_nx = S_SPACER;
                else         st_nx = S_DRAIN;
            end
            S_FAULT: begin
                if (ns) st_nx = S_SPACER;
            end
            default: st_nx = S_SPACER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_SPACER;
        else        st <= st_nx;
    end

    always_comb begin
        word_ok   = 1'b0;
        seq_fault = 1'b0;
        unique case (st)
            S_DATA:  word_ok   = 1'b1;
            S_FAULT: seq_fault = 1'b1;
            default: ;
        endcase
    end

    // R10: a fault is left only through an all-spacer capture
    p_fault_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fault && !ns) |=> seq_fault);

    // R12: re-capturing the held valid word keeps the monitor in DATA
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && nv && same) |=> (word_ok && !seq_fault));

endmodule

// File: rtl/dr_xor_top.sv
module dr_xor_top
    import dr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] a_dr,
    input  logic [2*W-1:0] b_dr,
    output logic [2*W-1:0] xor_dr,
    output logic [2*W-1:0] xnor_dr,
    output logic           word_ok,
    output logic           seq_fault
);

    localparam int NW = 2 * W;

    logic [NW-1:0] x_nx;
    logic [NW-1:0] xn_nx;
    logic          past_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        dr_xor_slice u_slice (
            .a (a_dr[2*i +: 2]),
            .b (b_dr[2*i +: 2]),
            .x (x_nx[2*i +: 2])
        );
    end

    dr_inv #(.W(W)) u_not (.x(x_nx), .y(xn_nx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xor_dr  <= '0;
            xnor_dr <= '0;
            past_ok <= 1'b0;
        end else begin
            xor_dr  <= x_nx;
            xnor_dr <= xn_nx;
            past_ok <= 1'b1;
        end
    end

    dr_phase_mon #(.W(W)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (x_nx),
        .cur       (xor_dr),
        .word_ok   (word_ok),
        .seq_fault (seq_fault)
    );

    function automatic logic word_valid(input logic [NW-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < W; i++) ok &= pair_valid(w[2*i +: 2]);
        return ok;
    endfunction

    // R4: all-00 inputs give all-00 outputs one edge later
    p_spacer_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(a_dr == '0 && b_dr == '0))
            |-> (xor_dr == '0 && xnor_dr == '0));

    // R4: all-11 inputs give all-11 outputs one edge later
    p_spacer_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(a_dr == '1 && b_dr == '1))
            |-> (xor_dr == '1 && xnor_dr == '1));

    // R6: every valid result pair is complemented on the NOT output
    p_inv_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid(xor_dr) |-> (xnor_dr == ~xor_dr));

    // R9: the monitor flags only complete words
    p_ok_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok |-> word_valid(xor_dr));

    // R9: entry into DATA comes from a word that was not complete
    p_ok_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(word_ok)) |-> !word_valid($past(xor_dr)));

    // R10: a fault is raised only by a complete data word
    p_fault_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_fault) |-> word_valid(xor_dr));

endmodule

// File: tb/dr_xor_top_bench.sv
module dr_xor_top_bench;

    localparam int W  = 4;
    localparam int NW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NW-1:0] a_dr, b_dr;
    logic [NW-1:0] xor_dr, xnor_dr;
    logic          word_ok, seq_fault;

    logic [1:0] c_a, c_b, c_o, c_r;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    dr_xor_top #(.W(W)) u_dr_xor_top (
        .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr),
        .xor_dr(xor_dr), .xnor_dr(xnor_dr),
        .word_ok(word_ok), .seq_fault(seq_fault)
    );

    dr_cell u_cell (.a(c_a), .b(c_b), .o(c_o), .r(c_r));

    // {a, b, o, r}; 10 = one, 01 = zero
    localparam logic [7:0] CELL_TV [12] = '{
        8'b10_10_01_01, 8'b10_01_10_01, 8'b01_10_10_01, 8'b01_01_10_10,
        8'b00_00_11_11, 8'b11_11_00_00, 8'b00_10_11_11, 8'b10_11_00_00,
        8'b11_01_00_00, 8'b01_00_11_11, 8'b00_11_11_11, 8'b11_00_00_00
    };
    localparam string CELL_TAG [12] = '{
        "R2 R3", "R2 R3", "R2 R3", "R2 R3", "R4", "R4",
        "R5", "R5", "R5", "R5", "R5", "R5"
    };

    // {a, b} operand values for the datapath walk
    localparam logic [7:0] TOP_TV [6] = '{
        8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h96, 8'h71
    };

    function automatic logic [NW-1:0] enc(input logic [W-1:0] v);
        logic [NW-1:0] w;
        for (int i = 0; i < W; i++) w[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
        return w;
    endfunction

    function automatic logic [NW-1:0] ref_xor(input logic [NW-1:0] a, input logic [NW-1:0] b);
        logic [NW-1:0] w;
        for (int i = 0; i < W; i++) begin
            logic [1:0] pa, pb;
            pa = a[2*i +: 2];
            pb = b[2*i +: 2];
            if ((pa[1] ^ pa[0]) && (pb[1] ^ pb[0]))
                w[2*i +: 2] = (pa[1] ^ pb[1]) ? 2'b10 : 2'b01;
            else if (!(pa[1] ^ pa[0]))
                w[2*i +: 2] = pa;
            else
                w[2*i +: 2] = pb;
        end
        return w;
    endfunction

    function automatic logic [NW-1:0] swap_w(input logic [NW-1:0] x);
        logic [NW-1:0] y;
        for (int i = 0; i < W; i++) y[2*i +: 2] = {x[2*i], x[2*i+1]};
        return y;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [NW-1:0] a, input logic [NW-1:0] b);
        @(negedge clk);
        a_dr = a;
        b_dr = b;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_word(input string tag, input logic [NW-1:0] a, input logic [NW-1:0] b);
        chk({tag, " R7 xor"}, 32'(xor_dr), 32'(ref_xor(a, b)));
        chk({tag, " R6 xnor"}, 32'(xnor_dr), 32'(swap_w(ref_xor(a, b))));
    endtask

    initial begin
        logic [2*NW-1:0] snap;
        rst_n = 1'b0;
        a_dr  = '0;
        b_dr  = '0;
        c_a   = 2'b00;
        c_b   = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 xor", 32'(xor_dr), 32'h0);
        chk("R8 xnor", 32'(xnor_dr), 32'h0);
        chk("R8 flags", {30'd0, word_ok, seq_fault}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // cell truth table, R1 encoding
        for (int k = 0; k < 12; k++) begin
            c_a = CELL_TV[k][7:6];
            c_b = CELL_TV[k][5:4];
            #1;
            chk({CELL_TAG[k], " R1 cell"}, {28'd0, c_o, c_r}, {28'd0, CELL_TV[k][3:0]});
        end

        // datapath walk: spacer, data, spacer
        for (int k = 0; k < 6; k++) begin
            logic [NW-1:0] av, bv;
            av = enc(TOP_TV[k][7:4]);
            bv = enc(TOP_TV[k][3:0]);
            apply('0, '0);
            chk("R4 spacer", 32'(xor_dr), 32'h0);
            snap = {xnor_dr, xor_dr};
            apply(av, bv);
            chk_word("walk", av, bv);
            chk("R9 ok", {31'd0, word_ok}, 32'd1);
            chk("R10 nofault", {31'd0, seq_fault}, 32'd0);
            chk("R11 rise", $countones(snap ^ {xnor_dr, xor_dr}), 2 * W);
            snap = {xnor_dr, xor_dr};
            apply('0, '0);
            chk("R11 fall", $countones(snap ^ {xnor_dr, xor_dr}), 2 * W);
            chk("R9 ok off", {31'd0, word_ok}, 32'd0);
        end

        // R12 hold
        apply(enc(4'hA), enc(4'h3));
        apply(enc(4'hA), enc(4'h3));
        apply(enc(4'hA), enc(4'h3));
        chk("R12 hold", {30'd0, word_ok, seq_fault}, 32'b10);

        // R10 data straight after different data
        apply(enc(4'h5), enc(4'h3));
        chk("R10 direct", {30'd0, word_ok, seq_fault}, 32'b01);
        apply(enc(4'h0), enc(4'h0));
        chk("R10 sticky", {31'd0, seq_fault}, 32'd1);
        apply('0, '0);
        chk("R10 clear", {30'd0, word_ok, seq_fault}, 32'b00);

        // R4 high spacer
        apply('1, '1);
        chk("R4 high", {xnor_dr, xor_dr}, {2 * NW{1'b1}});

        // R5 / R7 mixed spacer word, partial -> FILL
        begin
            logic [NW-1:0] am, bm;
            am = enc(4'b1010);
            am[1:0] = 2'b00;
            bm = enc(4'b0110);
            bm[7:6] = 2'b11;
            apply('0, '0);
            apply(am, bm);
            chk_word("R5 mixed", am, bm);
            chk("R9 fill", {30'd0, word_ok, seq_fault}, 32'b00);
            apply(enc(4'b1010), enc(4'b0110));
            chk("R9 after fill", {30'd0, word_ok, seq_fault}, 32'b10);
            apply(am, bm);
            chk("R10 drain", {30'd0, word_ok, seq_fault}, 32'b00);
            apply(enc(4'b1010), enc(4'b0110));
            chk("R10 drain data", {30'd0, word_ok, seq_fault}, 32'b01);
            apply('0, '0);
        end

        // R5 both spacers, A governs
        apply('0, '1);
        chk("R5 governs", {xnor_dr, xor_dr}, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule